// File: doc/BRIEF.md
# Sequential Trial-Division Primality Tester

This block decides whether an unsigned input number is prime by trial division. After a start request it tries the divisors 2, 3, 4 and so on, one at a time. For each candidate it forms the candidate's square and the remainder of the number divided by the candidate. The loop ends on the first candidate that divides the number, which gives a verdict of composite. It also ends on the first candidate whose square is larger than the number, which gives a verdict of prime. Because the loop can end early, the run time depends on the input.

A client drives the number and raises `start` for one cycle while the block is idle. The block reports `busy` while a test is in progress. It raises `done` for exactly one cycle when `isPrime` holds the new verdict. The verdict stays on the output until the next test finishes. Both the square and the remainder come from iterative units inside the block: a shift-add multiplier and a restoring shift-subtract divider. These two units run side by side for each candidate. The inputs 0 and 1 are reported as not prime without any trial.

Top module: `prime_trial_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy`, `done` and `isPrime` are all 0.
- R2: A `start` seen while idle captures `numIn` and raises `busy` in the next cycle. A `start` seen while `busy` is high has no effect: the running test keeps its number, its verdict and its latency.
- R3: For `numIn` of 0 or 1, the verdict is 0 and `done` is high in the first cycle after the start edge.
- R4: For `numIn` of 2 or more, treated as an unsigned NUM_W-bit value, the verdict is 1 exactly when no integer d with 2 ≤ d and d·d ≤ numIn divides it. This holds for values with the most significant bit set.
- R5: Candidates are tried in ascending order from 2, and each trial occupies NUM_W+2 cycles. With k the number of candidates tried, `done` rises 1 + k·(NUM_W+2) cycles after the start edge. For a composite number, k is its smallest factor minus 1. For a prime, k counts the candidates up to and including the first one whose square exceeds the number.
- R6: `isPrime` changes only in a cycle where `done` is high, and it holds its value between tests whatever `numIn` does.
- R7: `done` is a single-cycle pulse that is raised only while `busy` is high. `busy` falls in the cycle after `done`.
- R8: A square above the number takes precedence over a zero remainder. For this reason the number 2 is reported as prime, even though candidate 2 divides it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to test `numIn`; taken only while idle |
| numIn | input | NUM_W | Unsigned number to test |
| busy | output | 1 | High from the cycle after an accepted start through the `done` cycle |
| done | output | 1 | One-cycle pulse: `isPrime` holds a fresh verdict |
| isPrime | output | 1 | Verdict of the last test: 1 prime, 0 not prime |

## Verification
The bound checker watches the handshake on every cycle. It checks the single-cycle `done` pulse and that `done` sits inside `busy`. It checks that `busy` rises only after a start and falls only after `done`, and that the verdict moves only with `done`. It also checks that the two arithmetic units are never relaunched while either one is still iterating.

The verdicts themselves, the data-dependent latency and the ascending candidate order can only be shown by the bench. It does this by sweeping every number from 0 to 255, plus a set of large primes and composites, including values with the top bit set and a composite whose smallest factor is large. Two more effects also need directed scenarios: a start arriving mid-test that must be ignored, and the case n = 2, where the square check must take priority.

// File: rtl/prime_trial_pkg.sv
package prime_trial_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadNum;   // capture the number, reset candidate to 2
    logic launch;    // start square and remainder units on current candidate
    logic nextCand;  // advance candidate by one
    logic publish;   // write verdict into result register
    logic verdict;   // value written on publish
  } ctrlStrobe_t;

  // Status from the datapath back to the control FSM
  typedef struct packed {
    logic inBelowTwo;   // live input is 0 or 1
    logic unitsIdle;    // both iterative units have finished
    logic squareAbove;  // candidate squared exceeds captured number
    logic remZero;      // captured number divisible by candidate
  } dpStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINISH = 2'd3
  } ctrlState_t;

endpackage

// File: rtl/prime_square_unit.sv
// Shift-add squarer: opIn * opIn over OP_W iterations.
module prime_square_unit #(
  parameter int OP_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  input  logic [OP_W-1:0]   opIn,
  output logic              running,
  output logic [2*OP_W-1:0] product
);

  localparam int PROD_W = 2 * OP_W;
  localparam int CNT_W  = $clog2(OP_W + 1);

  logic [PROD_W-1:0] mcandR;
  logic [OP_W-1:0]   mplierR;
  logic [PROD_W-1:0] accR;
  logic [CNT_W-1:0]  cntR;
  logic              runR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandR  <= '0;
      mplierR <= '0;
      accR    <= '0;
      cntR    <= '0;
      runR    <= 1'b0;
    end else if (go) begin
      mcandR  <= PROD_W'(opIn);
      mplierR <= opIn;
      accR    <= '0;
      cntR    <= CNT_W'(OP_W);
      runR    <= 1'b1;
    end else if (runR) begin
      if (mplierR[0]) begin
        accR <= accR + mcandR;
      end
      mcandR  <= mcandR << 1;
      mplierR <= mplierR >> 1;
      cntR    <= cntR - CNT_W'(1);
      if (cntR == CNT_W'(1)) begin
        runR <= 1'b0;
      end
    end
  end

  assign running = runR;
  assign product = accR;

endmodule

// File: rtl/prime_rem_unit.sv
// Restoring shift-subtract divider; only the remainder is kept.
module prime_rem_unit #(
  parameter int NUM_W = 32,
  parameter int DIV_W = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [NUM_W-1:0] dividendIn,
  input  logic [DIV_W-1:0] divisorIn,
  output logic             running,
  output logic [NUM_W-1:0] remainder
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] remR;
  logic [NUM_W-1:0] shiftR;
  logic [NUM_W-1:0] divisorR;
  logic [CNT_W-1:0] cntR;
  logic             runR;

  logic [NUM_W:0] shifted;
  logic [NUM_W:0] trial;

  always_comb begin
    shifted = {remR, shiftR[NUM_W-1]};
    trial   = shifted - {1'b0, divisorR};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR     <= '0;
      shiftR   <= '0;
      divisorR <= '0;
      cntR     <= '0;
      runR     <= 1'b0;
    end else if (go) begin
      remR     <= '0;
      shiftR   <= dividendIn;
      divisorR <= NUM_W'(divisorIn);
      cntR     <= CNT_W'(NUM_W);
      runR     <= 1'b1;
    end else if (runR) begin
      // negative trial: restore the shifted partial remainder
      remR   <= trial[NUM_W] ? shifted[NUM_W-1:0] : trial[NUM_W-1:0];
      shiftR <= shiftR << 1;
      cntR   <= cntR - CNT_W'(1);
      if (cntR == CNT_W'(1)) begin
        runR <= 1'b0;
      end
    end
  end

  assign running   = runR;
  assign remainder = remR;

endmodule

// File: rtl/prime_trial_ctrl.sv
module prime_trial_ctrl
  import prime_trial_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  ctrlState_t stateR;
  ctrlState_t stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR <= ST_IDLE;
    end else begin
      stateR <= stateNext;
    end
  end

  always_comb begin
    stateNext = stateR;
    strobe    = '0;
    unique case (stateR)
      ST_IDLE: begin
        if (start) begin
          if (status.inBelowTwo) begin
            strobe.publish = 1'b1;
            strobe.verdict = 1'b0;
            stateNext      = ST_FINISH;
          end else begin
            strobe.loadNum = 1'b1;
            stateNext      = ST_LAUNCH;
          end
        end
      end
      ST_LAUNCH: begin
        strobe.launch = 1'b1;
        stateNext     = ST_WAIT;
      end
      ST_WAIT: begin
        if (status.unitsIdle) begin
          if (status.squareAbove) begin
            // square check wins over a zero remainder
            strobe.publish = 1'b1;
            strobe.verdict = 1'b1;
            stateNext      = ST_FINISH;
          end else if (status.remZero) begin
            strobe.publish = 1'b1;
            strobe.verdict = 1'b0;
            stateNext      = ST_FINISH;
          end else begin
            strobe.nextCand = 1'b1;
            stateNext       = ST_LAUNCH;
          end
        end
      end
      ST_FINISH: begin
        stateNext = ST_IDLE;
      end
      default: begin
        stateNext = ST_IDLE;
      end
    endcase
  end

  assign busy = (stateR != ST_IDLE);
  assign done = (stateR == ST_FINISH);

endmodule

// File: rtl/prime_trial_dp.sv
module prime_trial_dp
  import prime_trial_pkg::*;
#(
  parameter int NUM_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM_W-1:0] numIn,
  input  ctrlStrobe_t      strobe,
  output dpStatus_t        status,
  output logic             isPrime
);

  localparam int CAND_W = NUM_W / 2 + 1;
  localparam int SQ_W   = 2 * CAND_W;

  logic [NUM_W-1:0]  numR;
  logic [CAND_W-1:0] candR;
  logic              resultR;

  logic              sqRunning;
  logic [SQ_W-1:0]   sqValue;
  logic              remRunning;
  logic [NUM_W-1:0]  remValue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      numR    <= '0;
      candR   <= '0;
      resultR <= 1'b0;
    end else begin
      if (strobe.loadNum) begin
        numR  <= numIn;
        candR <= CAND_W'(2);
      end else if (strobe.nextCand) begin
        candR <= candR + CAND_W'(1);
      end
      if (strobe.publish) begin
        resultR <= strobe.verdict;
      end
    end
  end

  prime_square_unit #(
    .OP_W (CAND_W)
  ) u_square (
    .clk     (clk),
    .rstN    (rstN),
    .go      (strobe.launch),
    .opIn    (candR),
    .running (sqRunning),
    .product (sqValue)
  );

  prime_rem_unit #(
    .NUM_W (NUM_W),
    .DIV_W (CAND_W)
  ) u_rem (
    .clk        (clk),
    .rstN       (rstN),
    .go         (strobe.launch),
    .dividendIn (numR),
    .divisorIn  (candR),
    .running    (remRunning),
    .remainder  (remValue)
  );

  always_comb begin
    status.inBelowTwo  = (numIn < NUM_W'(2));
    status.unitsIdle   = !sqRunning && !remRunning;
    status.squareAbove = (sqValue > SQ_W'(numR));
    status.remZero     = (remValue == '0);
  end

  assign isPrime = resultR;

endmodule

// File: rtl/prime_trial_top.sv
module prime_trial_top
  import prime_trial_pkg::*;
#(
  parameter int NUM_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] numIn,
  output logic             busy,
  output logic             done,
  output logic             isPrime
);

  ctrlStrobe_t strobeW;
  dpStatus_t   statusW;

  prime_trial_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .status (statusW),
    .strobe (strobeW),
    .busy   (busy),
    .done   (done)
  );

  prime_trial_dp #(
    .NUM_W (NUM_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .numIn   (numIn),
    .strobe  (strobeW),
    .status  (statusW),
    .isPrime (isPrime)
  );

endmodule

// File: rtl/prime_trial_chk.sv
module prime_trial_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic isPrime,
  input logic launch,
  input logic unitsIdle
);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R6
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(isPrime) |-> done);

  // R5
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    launch |-> unitsIdle);

endmodule

bind prime_trial_top prime_trial_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .isPrime   (isPrime),
  .launch    (strobeW.launch),
  .unitsIdle (statusW.unitsIdle)
);

// File: tb/test_prime_trial_top.sv
module test_prime_trial_top;

  localparam int NUM_W = 32;
  localparam int STEP  = NUM_W + 2;
  localparam int LIMIT = 60000;

  logic             clk = 1'b0;
  logic             rstN;
  logic             start;
  logic [NUM_W-1:0] numIn;
  logic             busy;
  logic             done;
  logic             isPrime;

  int compared   = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  prime_trial_top #(.NUM_W(NUM_W)) i_prime_trial_top (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .numIn   (numIn),
    .busy    (busy),
    .done    (done),
    .isPrime (isPrime)
  );

  // Reference: candidates tried and verdict, per R3/R4/R5/R8
  function automatic void refModel(input longint n, output int tries, output bit prime);
    tries = 0;
    prime = 1'b0;
    if (n < 2) return;
    for (longint d = 2; ; d++) begin
      tries++;
      if (d * d > n) begin prime = 1'b1; return; end
      if (n % d == 0) begin prime = 1'b0; return; end
    end
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one test; optionally injects a second start mid-run (R2)
  task automatic runOne(input longint n, input string req, input int injectAt,
                        input longint injectNum);
    int  tries;
    bit  expPrime;
    int  cyc;
    longint expLat;
    refModel(n, tries, expPrime);
    expLat = 1 + longint'(tries) * STEP;
    @(negedge clk);
    numIn = n[NUM_W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < LIMIT) begin
      if (injectAt != 0 && cyc == injectAt) begin
        numIn = injectNum[NUM_W-1:0];
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    check(isPrime == expPrime, req, $sformatf("verdict n=%0d", n), isPrime, expPrime);
    check(cyc == expLat, "R5", $sformatf("latency n=%0d", n), cyc, expLat);
    @(negedge clk);
    check(!done && !busy, "R7", $sformatf("done/busy after n=%0d", n), {done, busy}, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual 195000 cycles expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bit held;
    rstN  = 1'b0;
    start = 1'b0;
    numIn = '0;
    repeat (3) @(negedge clk);
    check({busy, done, isPrime} == 3'b000, "R1", "outputs in reset", {busy, done, isPrime}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, isPrime} == 3'b000, "R1", "outputs after reset", {busy, done, isPrime}, 0);

    // R3: below two
    runOne(0, "R3", 0, 0);
    runOne(1, "R3", 0, 0);
    // R8: two divides itself but its square is above
    runOne(2, "R8", 0, 0);

    // R4: exhaustive small sweep
    for (int v = 3; v < 256; v++) begin
      runOne(longint'(v), "R4", 0, 0);
    end

    // R4: large values, top bit set included
    runOne(65521, "R4", 0, 0);
    runOne(64507, "R4", 0, 0);
    runOne(1000001, "R4", 0, 0);
    runOne(999983, "R4", 0, 0);
    runOne(64'd4294967295, "R4", 0, 0);
    runOne(64'd4294836225, "R4", 0, 0);

    // R2: second start during a run is ignored (97 prime, 100 composite)
    runOne(97, "R2", 20, 100);
    runOne(91, "R2", 5, 2);

    // R6: verdict holds while input moves and no start is given
    held = isPrime;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      numIn = NUM_W'(j * 7 + 4);
      if (isPrime != held || busy) begin
        check(1'b0, "R6", "verdict hold", {busy, isPrime}, held);
      end
    end
    check(isPrime == held && !busy, "R6", "verdict after idle input changes", isPrime, held);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule